// File: doc/BRIEF.md
# ADC conversion control sequencer

This block is the digital sequencer for a successive-approximation converter that runs one conversion each time software asks for one. Software sets a level-style enable, writes a start pulse, picks an input channel and a prescaler code. The block makes a one-cycle ADC clock enable from the system clock. It drives the channel multiplexer select and sends start and sample strobes to the analog comparator model. It then reports completion with a one-cycle strobe and a sticky interrupt flag.

The first conversion after each enable is preceded by an initialisation phase of the same length as a conversion. The prescaler runs only while the block is enabled, counting from the moment of enable. A channel change that arrives during a conversion waits until that conversion has ended.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While enabled, `adc_clk_en_o` pulses for one cycle every N system cycles. N is 2, 2, 4, 8, 16, 32, 64, 128 for `ps_sel_i` codes 0 to 7. Counting the first enabled cycle as cycle 1, the first pulse falls in cycle N and the second in cycle 2N.
- R2: While `en_i` is low the prescaler is held cleared and `adc_clk_en_o` stays low.
- R3: A start is accepted only from idle, with `en_i` high and `start_wr_i` high at a clock edge. `busy_o` is then high from the next cycle. Start writes made while busy or while disabled have no effect: a disabled write leaves `busy_o` low, and a write while busy does not lengthen the conversion.
- R4: A normal conversion ends on the 13th `adc_clk_en_o` pulse seen while `busy_o` is high. `done_o` is high for exactly that cycle, and `busy_o` is low from the next cycle.
- R5: The first conversion after an enable ends on the 26th pulse. `conv_start_o` marks pulse 14 of a first conversion and pulse 1 of a normal one, and `sample_o` marks the pulse after `conv_start_o`.
- R6: While idle, `chan_sel_o` takes the value of `chan_i` one cycle later. During a conversion it holds the channel captured at the start. A change made mid-conversion shows on `chan_sel_o` in the second cycle after `done_o`.
- R7: `irq_o` goes high in the cycle after `done_o` and stays high until a cycle after `irq_clr_i` is seen high. A completion in the same cycle as a clear leaves it set.
- R8: Dropping `en_i` aborts a conversion in progress. `busy_o` is low from the next cycle, no `done_o` follows, and the next conversion again takes 26 pulses.
- R9: After reset `busy_o`, `done_o`, `irq_o`, `adc_clk_en_o` are low and `chan_sel_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Converter enable level |
| start_wr_i | input | 1 | Write of 1 to the start bit |
| chan_i | input | CH_W | Requested input channel |
| ps_sel_i | input | SEL_W | Prescaler divide code |
| irq_clr_i | input | 1 | Write of 1 to clear the interrupt flag |
| adc_clk_en_o | output | 1 | One-cycle ADC clock enable |
| chan_sel_o | output | CH_W | Channel multiplexer select |
| conv_start_o | output | 1 | Start strobe to the comparator model |
| sample_o | output | 1 | Sample strobe to the comparator model |
| busy_o | output | 1 | Start bit readback, high while converting |
| done_o | output | 1 | Completion strobe |
| irq_o | output | 1 | Sticky completion interrupt flag |

## Verification
A scoreboard counts ADC clock pulses during each conversion. It catches a design that skips or doubles the initialisation phase, or fails to re-arm it after an abort, because the count would come out 13 where 26 is due or the reverse. It also checks the channel at completion and two cycles later, so a design that switches the multiplexer mid-conversion shows the new channel too early. Prescaler tests measure the first and second pulse from enable for every code, which exposes a free-running counter or a wrong code mapping. Further cases cover a start written while busy extending the conversion, a disabled start being accepted, and a clear that beats a coincident completion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INIT = 2'd1,
    ST_CONV = 2'd2
  } conv_st_e;
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
  parameter int PS_W  = 7,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PS_W-1:0] cnt_q;
  logic [PS_W-1:0] mask;
  logic [4:0]      shamt;

  // code 0 aliases code 1 (divide by 2)
  always_comb begin
    shamt = (sel_i == '0) ? 5'd1 : 5'(sel_i);
    mask  = PS_W'((32'd1 << shamt) - 32'd1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && ((cnt_q & mask) == mask);

  // R1
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/adc_conv_fsm.sv
module adc_conv_fsm
  import adc_seq_pkg::*;
#(
  parameter int CH_W        = 3,
  parameter int CONV_TICKS  = 13,
  parameter int INIT_TICKS  = 13,
  parameter int SAMPLE_TICK = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            tick_i,
  input  logic            start_wr_i,
  input  logic [CH_W-1:0] chan_i,
  output logic [CH_W-1:0] chan_sel_o,
  output logic            busy_o,
  output logic            conv_start_o,
  output logic            sample_o,
  output logic            done_o
);
  localparam int MAXT = (CONV_TICKS > INIT_TICKS) ? CONV_TICKS : INIT_TICKS;
  localparam int TC_W = $clog2(MAXT + 1);
  localparam logic [TC_W-1:0] CONV_LAST = TC_W'(CONV_TICKS - 1);
  localparam logic [TC_W-1:0] INIT_LAST = TC_W'(INIT_TICKS - 1);
  localparam logic [TC_W-1:0] SMP_AT    = TC_W'(SAMPLE_TICK);

  conv_st_e        st_q;
  logic [TC_W-1:0] tcnt_q;
  logic            first_q;
  logic [CH_W-1:0] chan_q;
  logic            init_end;

  assign init_end     = (st_q == ST_INIT) && tick_i && (tcnt_q == INIT_LAST);
  assign done_o       = (st_q == ST_CONV) && tick_i && (tcnt_q == CONV_LAST);
  assign conv_start_o = (st_q == ST_CONV) && tick_i && (tcnt_q == '0);
  assign sample_o     = (st_q == ST_CONV) && tick_i && (tcnt_q == SMP_AT);
  assign busy_o       = (st_q != ST_IDLE);
  assign chan_sel_o   = chan_q;

  // channel tracks request only while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               chan_q <= '0;
    else if (st_q == ST_IDLE)  chan_q <= chan_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      tcnt_q  <= '0;
      first_q <= 1'b1;
    end else if (!en_i) begin
      st_q    <= ST_IDLE;
      tcnt_q  <= '0;
      first_q <= 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_wr_i) begin
          st_q   <= first_q ? ST_INIT : ST_CONV;
          tcnt_q <= '0;
        end
        ST_INIT: if (tick_i) begin
          if (init_end) begin
            st_q    <= ST_CONV;
            tcnt_q  <= '0;
            first_q <= 1'b0;
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        ST_CONV: if (tick_i) begin
          if (done_o) begin
            st_q   <= ST_IDLE;
            tcnt_q <= '0;
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  // R6
  chan_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(chan_sel_o));
  // R3
  start_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(start_wr_i) && $past(en_i)));
  // R8
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !busy_o);
endmodule

// File: rtl/adc_irq_flag.sv
module adc_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic clr_i,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     irq_o <= 1'b0;
    else if (done_i) irq_o <= 1'b1;
    else if (clr_i)  irq_o <= 1'b0;
  end

  // R7
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> irq_o);
  // R7
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i) |=> irq_o);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int CH_W        = 3,
  parameter int SEL_W       = 3,
  parameter int PS_W        = 7,
  parameter int CONV_TICKS  = 13,
  parameter int INIT_TICKS  = 13,
  parameter int SAMPLE_TICK = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_wr_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic [SEL_W-1:0] ps_sel_i,
  input  logic             irq_clr_i,
  output logic             adc_clk_en_o,
  output logic [CH_W-1:0]  chan_sel_o,
  output logic             conv_start_o,
  output logic             sample_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             irq_o
);
  logic tick;

  adc_prescaler #(.PS_W(PS_W), .SEL_W(SEL_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .sel_i(ps_sel_i), .tick_o(tick)
  );

  adc_conv_fsm #(
    .CH_W(CH_W), .CONV_TICKS(CONV_TICKS), .INIT_TICKS(INIT_TICKS),
    .SAMPLE_TICK(SAMPLE_TICK)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .tick_i(tick),
    .start_wr_i(start_wr_i), .chan_i(chan_i), .chan_sel_o(chan_sel_o),
    .busy_o(busy_o), .conv_start_o(conv_start_o), .sample_o(sample_o),
    .done_o(done_o)
  );

  adc_irq_flag u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done_o), .clr_i(irq_clr_i),
    .irq_o(irq_o)
  );

  assign adc_clk_en_o = tick;

  // R5
  strobe_in_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_start_o || sample_o) |-> (busy_o && adc_clk_en_o));
endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, start_wr = 1'b0, irq_clr = 1'b0;
  logic [2:0] chan = '0, sel = '0;
  logic       tick, conv_start, sample, busy, done, irq;
  logic [2:0] chan_sel;

  int nchk = 0, nfail = 0;

  typedef struct { int ch; int ticks; int cs_at; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  adc_seq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .start_wr_i(start_wr),
    .chan_i(chan), .ps_sel_i(sel), .irq_clr_i(irq_clr),
    .adc_clk_en_o(tick), .chan_sel_o(chan_sel), .conv_start_o(conv_start),
    .sample_o(sample), .busy_o(busy), .done_o(done), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp_v);
    nchk++;
    if (act != exp_v) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp_v);
    end
  endtask

  // monitor / scoreboard
  int tk = 0, cs_at = 0, sp_at = 0;
  always begin
    @(negedge clk); #1;
    if (busy && tick) tk++;
    if (conv_start) cs_at = tk;
    if (sample) sp_at = tk;
    if (done) begin
      if (q.size() == 0) chk("R8 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk("R4/R5 tick count", tk, e.ticks);
        chk("R5 conv_start pos", cs_at, e.cs_at);
        chk("R5 sample pos", sp_at, e.cs_at + 1);
        chk("R6 chan at done", int'(chan_sel), e.ch);
      end
      tk = 0; cs_at = 0; sp_at = 0;
    end else if (!busy) begin
      tk = 0; cs_at = 0; sp_at = 0;
    end
  end

  task automatic run_conv(input int ch, input bit first, input int mid_ch,
                          input bit rewr, input bit clr_hold);
    exp_t e;
    @(negedge clk);
    start_wr = 1'b1; chan = 3'(ch);
    e.ch = ch; e.ticks = first ? 26 : 13; e.cs_at = first ? 14 : 1;
    q.push_back(e);
    @(negedge clk);
    start_wr = 1'b0;
    if (mid_ch >= 0) chan = 3'(mid_ch);
    if (clr_hold) irq_clr = 1'b1;
    #1 chk("R3 busy after start", int'(busy), 1);
    if (rewr) begin
      repeat (5) @(negedge clk);
      start_wr = 1'b1;
      @(negedge clk);
      start_wr = 1'b0;
    end
    do begin @(negedge clk); #1; end while (!done);
    @(negedge clk);
    if (clr_hold) irq_clr = 1'b0;
    #1 chk("R4 busy low after done", int'(busy), 0);
    if (clr_hold) chk("R7 set beats clear", int'(irq), 1);
    @(negedge clk); #1;
    if (mid_ch >= 0) chk("R6 deferred chan", int'(chan_sel), mid_ch);
  endtask

  task automatic div_test(input int s);
    int n, first_t, second_t;
    n = (s == 0) ? 2 : (1 << s);
    first_t = 0; second_t = 0;
    @(negedge clk); en = 1'b0; sel = 3'(s);
    @(negedge clk); #1 chk("R2 no tick disabled", int'(tick), 0);
    @(negedge clk); en = 1'b1;
    for (int i = 1; i <= 300; i++) begin
      #1;
      if (tick) begin
        if (first_t == 0) first_t = i;
        else if (second_t == 0) second_t = i;
      end
      @(negedge clk);
    end
    chk("R1 first tick", first_t, n);
    chk("R1 second tick", second_t, 2 * n);
  endtask

  initial begin
    #(4 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog act=1 exp=0");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9 busy", int'(busy), 0);
    chk("R9 done", int'(done), 0);
    chk("R9 irq", int'(irq), 0);
    chk("R9 tick", int'(tick), 0);
    chk("R9 chan", int'(chan_sel), 0);

    @(negedge clk); en = 1'b1; sel = 3'd2;
    run_conv(3, 1, -1, 0, 0);
    run_conv(5, 0, -1, 0, 0);
    run_conv(1, 0, 6, 0, 0);
    run_conv(2, 0, -1, 1, 0);
    chk("R7 irq sticky", int'(irq), 1);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    #1 chk("R7 irq cleared", int'(irq), 0);
    run_conv(7, 0, -1, 0, 1);

    // start while disabled ignored
    @(negedge clk); en = 1'b0;
    @(negedge clk); start_wr = 1'b1;
    @(negedge clk); start_wr = 1'b0;
    #1 chk("R3 disabled start ignored", int'(busy), 0);

    for (int s = 0; s < 8; s++) div_test(s);

    @(negedge clk); en = 1'b0; sel = 3'd7;
    @(negedge clk); en = 1'b1;
    run_conv(4, 1, -1, 0, 0);

    // abort mid-conversion
    @(negedge clk); sel = 3'd1;
    run_conv(0, 0, -1, 0, 0);
    @(negedge clk); start_wr = 1'b1; chan = 3'd5;
    @(negedge clk); start_wr = 1'b0;
    repeat (8) @(negedge clk);
    en = 1'b0;
    @(negedge clk); #1 chk("R8 busy after abort", int'(busy), 0);
    q.delete();
    repeat (40) @(negedge clk);
    en = 1'b1;
    run_conv(6, 1, -1, 0, 0);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule